// File: doc/BRIEF.md
# Seconds Timer with Alarm

This block is a free-running seconds counter for an always-powered domain. A programmable divider splits the slow clock into periodic advance pulses. Each pulse steps a counter by one. Software sets the divider to the slow-clock rate to get one advance per second. Software cannot load the counter. It can only send the counter back to zero by setting a restart bit in the control word.

An alarm word is compared with the counter on every advance. Two sticky event flags record alarm matches and counter advances. Reading the event word returns the flags and then clears them. A single interrupt line is raised while any flag is set and its enable bit is set.

Access is through a word-addressed register bus with a one-cycle select and a combinational read path. The block has four words. Control is at byte offset 0x00, alarm at 0x04, count at 0x08 and events at 0x0C. Only word-aligned accesses inside that range take effect.

Top module: `secs_timer`

## Requirements
- R1: After reset the control word, count and event word all read 0. The alarm word reads all ones over the counter width. The interrupt line is low.
- R2: In the control word at 0x00, bits [15:0] are the divider value, bit 16 is the alarm interrupt enable and bit 17 is the advance interrupt enable. These fields read back as written. Bit 18 (restart) and every bit above it read as 0.
- R3: With a divider value P other than 0, the counter advances by exactly one every P clock cycles. With P = 0 the counter holds its value.
- R4: Writing the control word with bit 18 set clears the counter and the divider phase in the cycle of the write. The new divider and enable fields are kept. The next advance comes P cycles later.
- R5: The count word at 0x08 is read-only. A write to it leaves the count unchanged.
- R6: The counter wraps from all ones to 0.
- R7: Event bit 1 is set on every counter advance, including the wrap.
- R8: Event bit 0 is set on the advance whose new count equals the alarm word. An alarm word of all ones never sets it.
- R9: Reading the event word at 0x0C returns bit 0 and bit 1 and clears both afterwards. A flag whose event occurs in the same cycle as the read stays set. Writes to the event word have no effect.
- R10: The interrupt line equals (event bit 0 AND control bit 16) OR (event bit 1 AND control bit 17), with no added delay.
- R11: The alarm word at 0x04 is read/write over the counter width. Bits above the counter width read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock that drives the divider and all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read and 0 otherwise |
| irq | output | 1 | Interrupt request: event flags gated by their enables |

## Verification
The embedded assertions watch every cycle for the following:
- The counter holds, steps or clears only as the divider pulse and restart allow.
- Restart zeroes both the counter and the divider phase.
- The flags rise after their events and drop after a read that has no competing event.
- An all-ones alarm never raises the alarm flag.
- Control read-back never shows the restart bit.

Some properties appear only in the bench's scenarios:
- The exact advance period, which is checked against a behavioural model.
- The wrap through zero.
- Reading the event word in a cycle that aligns with a divider pulse.
- Writes to the read-only words having no effect.

// File: rtl/secs_timer_pkg.sv
package secs_timer_pkg;

    // Word index taken from byte address bits [3:2]
    typedef enum logic [1:0] {
        WSEL_CTRL  = 2'd0,
        WSEL_ALARM = 2'd1,
        WSEL_COUNT = 2'd2,
        WSEL_EVENT = 2'd3
    } wsel_e;

    localparam int BUS_W     = 32;
    localparam int EV_ALARM  = 0;
    localparam int EV_STEP   = 1;
    localparam int EV_W      = 2;

endpackage

// File: rtl/secs_timer_divider.sv
module secs_timer_divider #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] period,
    output logic             pulse
);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } div_t;

    div_t div_d, div_q;
    logic running;
    logic wrap_c;

    always_comb begin
        div_d   = div_q;
        running = (period != '0);
        wrap_c  = running && (div_q.phase >= (period - 1'b1));
        if (restart || !running || wrap_c) begin
            div_d.phase = '0;
        end else begin
            div_d.phase = div_q.phase + 1'b1;
        end
        pulse = wrap_c && !restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    // R4
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> div_q.phase == '0);

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !pulse && period != '0 && $past(period) == period)
            |=> div_q.phase == $past(div_q.phase) + 1'b1);

endmodule

// File: rtl/secs_timer_counter.sv
module secs_timer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pulse,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] count,
    output logic             alarm_hit,
    output logic             step_hit
);

    localparam logic [CNT_W-1:0] OFF_MARK = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [CNT_W-1:0] next_val;

    always_comb begin
        cnt_d     = cnt_q;
        next_val  = cnt_q.value + 1'b1;
        step_hit  = pulse;
        alarm_hit = pulse && (next_val == alarm) && (alarm != OFF_MARK);
        if (restart) begin
            cnt_d.value = '0;
        end else if (pulse) begin
            cnt_d.value = next_val;
        end
        count = cnt_q.value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && !restart) |=> $stable(cnt_q.value));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !restart) |=> cnt_q.value == $past(cnt_q.value) + 1'b1);

    // R4
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q.value == '0);

    // R6
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !restart && cnt_q.value == OFF_MARK) |=> cnt_q.value == '0);

endmodule

// File: rtl/secs_timer_events.sv
module secs_timer_events
    import secs_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alarm_hit,
    input  logic            step_hit,
    input  logic            rd_clear,
    input  logic            alarm_ie,
    input  logic            step_ie,
    output logic [EV_W-1:0] flags,
    output logic            irq
);

    typedef struct packed {
        logic [EV_W-1:0] ev;
    } ev_t;

    ev_t ev_d, ev_q;
    logic [EV_W-1:0] raise;
    logic [EV_W-1:0] mask;

    always_comb begin
        raise            = '0;
        raise[EV_ALARM]  = alarm_hit;
        raise[EV_STEP]   = step_hit;
        mask             = '0;
        mask[EV_ALARM]   = alarm_ie;
        mask[EV_STEP]    = step_ie;
        ev_d             = ev_q;
        if (rd_clear) begin
            ev_d.ev = '0;
        end
        ev_d.ev = ev_d.ev | raise;
        flags   = ev_q.ev;
        irq     = |(ev_q.ev & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    // R7
    step_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_hit |=> ev_q.ev[EV_STEP]);

    // R9
    alarm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> ev_q.ev[EV_ALARM]);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !step_hit && !alarm_hit) |=> ev_q.ev == '0);

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ev_q.ev != '0) && (alarm_ie || step_ie));

endmodule

// File: rtl/secs_timer_csr.sv
module secs_timer_csr
    import secs_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int PRE_W  = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [EV_W-1:0]   flags,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [PRE_W-1:0]  period,
    output logic              alarm_ie,
    output logic              step_ie,
    output logic [CNT_W-1:0]  alarm,
    output logic              restart,
    output logic              rd_clear
);

    localparam int AIE_BIT = PRE_W;
    localparam int SIE_BIT = PRE_W + 1;
    localparam int RST_BIT = PRE_W + 2;

    typedef struct packed {
        logic [PRE_W-1:0] period;
        logic             alarm_ie;
        logic             step_ie;
        logic [CNT_W-1:0] alarm;
    } csr_t;

    csr_t  csr_d, csr_q;
    wsel_e wsel;
    logic  hi_ok;
    logic  hit;
    logic  do_wr;
    logic  do_rd;

    generate
        if (ADDR_W > 4) begin : g_hi_dec
            assign hi_ok = (bus_addr[ADDR_W-1:4] == '0);
        end else begin : g_no_hi
            assign hi_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        wsel  = wsel_e'(bus_addr[3:2]);
        hit   = bus_sel && hi_ok && (bus_addr[1:0] == 2'b00);
        do_wr = hit && bus_wr;
        do_rd = hit && !bus_wr;
        csr_d = csr_q;
        if (do_wr && wsel == WSEL_CTRL) begin
            csr_d.period   = bus_wdata[PRE_W-1:0];
            csr_d.alarm_ie = bus_wdata[AIE_BIT];
            csr_d.step_ie  = bus_wdata[SIE_BIT];
        end
        if (do_wr && wsel == WSEL_ALARM) begin
            csr_d.alarm = bus_wdata[CNT_W-1:0];
        end
        restart  = do_wr && (wsel == WSEL_CTRL) && bus_wdata[RST_BIT];
        rd_clear = do_rd && (wsel == WSEL_EVENT);

        bus_rdata = '0;
        if (do_rd) begin
            case (wsel)
                WSEL_CTRL: begin
                    bus_rdata[PRE_W-1:0] = csr_q.period;
                    bus_rdata[AIE_BIT]   = csr_q.alarm_ie;
                    bus_rdata[SIE_BIT]   = csr_q.step_ie;
                end
                WSEL_ALARM: bus_rdata[CNT_W-1:0] = csr_q.alarm;
                WSEL_COUNT: bus_rdata[CNT_W-1:0] = count;
                default:    bus_rdata[EV_W-1:0]  = flags;
            endcase
        end

        period   = csr_q.period;
        alarm_ie = csr_q.alarm_ie;
        step_ie  = csr_q.step_ie;
        alarm    = csr_q.alarm;
    end

    // R1: alarm word resets to the all-ones "no alarm" mark
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q.period   <= '0;
            csr_q.alarm_ie <= 1'b0;
            csr_q.step_ie  <= 1'b0;
            csr_q.alarm    <= {CNT_W{1'b1}};
        end else begin
            csr_q <= csr_d;
        end
    end

    // R11
    alarm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_wr && wsel == WSEL_ALARM) |=> $stable(csr_q.alarm));

endmodule

// File: rtl/secs_timer.sv
module secs_timer
    import secs_timer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int PRE_W  = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int RST_BIT = PRE_W + 2;

    logic [PRE_W-1:0] period;
    logic             alarm_ie;
    logic             step_ie;
    logic [CNT_W-1:0] alarm;
    logic             restart;
    logic             rd_clear;
    logic             pulse;
    logic [CNT_W-1:0] count;
    logic             alarm_hit;
    logic             step_hit;
    logic [EV_W-1:0]  flags;

    secs_timer_csr #(
        .ADDR_W (ADDR_W),
        .PRE_W  (PRE_W),
        .CNT_W  (CNT_W)
    ) csr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count),
        .flags     (flags),
        .bus_rdata (bus_rdata),
        .period    (period),
        .alarm_ie  (alarm_ie),
        .step_ie   (step_ie),
        .alarm     (alarm),
        .restart   (restart),
        .rd_clear  (rd_clear)
    );

    secs_timer_divider #(
        .PRE_W (PRE_W)
    ) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .period  (period),
        .pulse   (pulse)
    );

    secs_timer_counter #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .pulse     (pulse),
        .alarm     (alarm),
        .count     (count),
        .alarm_hit (alarm_hit),
        .step_hit  (step_hit)
    );

    secs_timer_events ev_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_hit (alarm_hit),
        .step_hit  (step_hit),
        .rd_clear  (rd_clear),
        .alarm_ie  (alarm_ie),
        .step_ie   (step_ie),
        .flags     (flags),
        .irq       (irq)
    );

    // R8
    alarm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm == {CNT_W{1'b1}} && !flags[EV_ALARM]) |=> !flags[EV_ALARM]);

    // R5
    count_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(8) && !pulse && !restart)
            |=> $stable(count));

    // R2
    ctrl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == '0) |-> bus_rdata[31:RST_BIT] == '0);

endmodule

// File: tb/secs_timer_tb_top.sv
module secs_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 10;
    localparam int MAXV       = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_presc, m_div, m_cnt, m_alarm;
    bit m_ae, m_ie, m_fa, m_fi;

    always #(CLK_PERIOD/2) clk = ~clk;

    secs_timer #(.ADDR_W(4), .PRE_W(16), .CNT_W(CW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        bit tk, rs, ea, ei;
        if (!rst_n) begin
            m_presc = 0; m_div = 0; m_cnt = 0; m_alarm = MAXV;
            m_ae = 0; m_ie = 0; m_fa = 0; m_fi = 0;
        end else begin
            tk = (m_presc != 0) && (m_div >= m_presc - 1);
            rs = bus_sel && bus_wr && bus_addr == 4'h0 && bus_wdata[18];
            ea = 0; ei = 0;
            if (rs) begin
                m_div = 0; m_cnt = 0;
            end else if (tk) begin
                m_div = 0;
                m_cnt = (m_cnt + 1) & MAXV;
                ei = 1;
                ea = (m_cnt == m_alarm) && (m_alarm != MAXV);
            end else if (m_presc == 0) begin
                m_div = 0;
            end else begin
                m_div = m_div + 1;
            end
            if (bus_sel && !bus_wr && bus_addr == 4'hC) begin
                m_fa = 0; m_fi = 0;
            end
            m_fa = m_fa | ea;
            m_fi = m_fi | ei;
            if (bus_sel && bus_wr && bus_addr == 4'h0) begin
                m_presc = int'(bus_wdata[15:0]);
                m_ae = bus_wdata[16];
                m_ie = bus_wdata[17];
            end
            if (bus_sel && bus_wr && bus_addr == 4'h4) m_alarm = int'(bus_wdata) & MAXV;
        end
    end

    // per-cycle comparison away from the rising edge
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        string tag;
        if (rst_n && !done) begin
            chk("R10 irq", {31'b0, irq}, {31'b0, (m_fa & m_ae) | (m_fi & m_ie)});
            exp_rd = '0;
            tag = "R2 idle-read";
            if (bus_sel && !bus_wr) begin
                case (bus_addr)
                    4'h0: begin exp_rd = 32'(m_presc) | (32'(m_ae) << 16) | (32'(m_ie) << 17); tag = "R2 ctrl"; end
                    4'h4: begin exp_rd = 32'(m_alarm); tag = "R11 alarm"; end
                    4'h8: begin exp_rd = 32'(m_cnt); tag = "R3 count"; end
                    4'hC: begin exp_rd = {30'b0, m_fi, m_fa}; tag = "R9 events"; end
                    default: exp_rd = '0;
                endcase
            end
            chk(tag, bus_rdata, exp_rd);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset values
        @(negedge clk); chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
        rd(4'h4, v); chk("R1 alarm", v, 32'h3FF);
        rd(4'h8, v); chk("R1 count", v, 32'h0);
        rd(4'hC, v); chk("R1 events", v, 32'h0);

        // R2 readback, restart bit reads 0; R4 restart clears count
        wr(4'h0, 32'h0007_0003);
        rd(4'h0, v); chk("R2 ctrl readback", v, 32'h0003_0003);
        repeat (20) @(posedge clk);
        wr(4'h0, 32'h0004_0004);
        rd(4'h8, v); chk("R4 count after restart", v, 32'h0);
        repeat (30) rd(4'h8, v);

        // R3 divider 0 stops counting
        wr(4'h0, 32'h0000_0000);
        rd(4'h8, v); repeat (10) @(posedge clk); rd(4'h8, v2);
        chk("R3 stopped count", v2, v);

        // R5 count word is read-only
        wr(4'h8, 32'h0000_0055);
        rd(4'h8, v2); chk("R5 count unchanged", v2, v);

        // R11 alarm word
        wr(4'h4, 32'h0000_02AB); rd(4'h4, v); chk("R11 alarm rw", v, 32'h2AB);
        wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, v); chk("R11 alarm width", v, 32'h3FF);

        // R8 alarm match
        rd(4'hC, v);
        wr(4'h4, 32'd5);
        wr(4'h0, 32'h0005_0002);
        repeat (14) @(posedge clk);
        @(negedge clk); chk("R8 R10 irq on alarm", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'h0001_0000);
        rd(4'hC, v); chk("R8 alarm flag", {31'b0, v[0]}, 32'h1);
        rd(4'hC, v); chk("R9 cleared after read", v, 32'h0);
        @(negedge clk); chk("R10 irq low after clear", {31'b0, irq}, 32'h0);

        // R9 writes to event word ignored
        wr(4'hC, 32'h3); rd(4'hC, v); chk("R9 event write ignored", v, 32'h0);

        // R9 reads aligned with divider pulses on both phases
        wr(4'h0, 32'h0006_0002);
        for (int i = 0; i < 6; i++) rd(4'hC, v);
        @(posedge clk);
        for (int i = 0; i < 6; i++) rd(4'hC, v);

        // R10 enables gate irq
        wr(4'h0, 32'h0006_0001);
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R10 irq with step enable", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'h0000_0001);
        @(negedge clk); chk("R10 irq masked", {31'b0, irq}, 32'h0);

        // R6 R7 R8 wrap with all-ones alarm
        wr(4'h4, 32'h3FF);
        wr(4'h0, 32'h0005_0001);
        rd(4'hC, v);
        repeat (1100) @(posedge clk);
        wr(4'h0, 32'h0001_0000);
        rd(4'hC, v);
        chk("R8 all-ones alarm never fires", {31'b0, v[0]}, 32'h0);
        chk("R7 step flag set", {31'b0, v[1]}, 32'h1);
        rd(4'h8, v);
        chk("R6 count wrapped", {31'b0, (v < 32'd200)}, 32'h1);

        repeat (2) @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule